// File: doc/BRIEF.md
# Masked Element-Wise Vector Add Executor

This block runs a single integer add across two source vector registers and writes the results into a destination register. A start pulse launches the operation. The block then steps through the register one lane group per clock, producing `LANES` adjacent elements in each cycle, until it has covered every element up to the register's maximum length. Each cycle it places the index of the group's first element on a read port and takes the source elements back combinationally. In the same cycle it drives a write data vector with one write enable per lane, and the register file captures that data on the next clock edge.

A 2-bit mode sets the shape of the result and the masking:

| Code | Shape | Which active elements receive the sum |
|------|-------|----------------------------------------|
| 00 | Scalar | All of them, each gets the sum of element 0 of the two sources |
| 01 | Vector | All of them (unmasked) |
| 10 | Vector | Those whose mask bit is 1; the rest receive zero |
| 11 | Vector | Those whose mask bit is 0; the rest receive zero |

Elements at or above the active length are written with zero, up to the maximum length. The final result does not depend on the lane count. A one-cycle done pulse reports completion. The register file may pass the destination as one of the sources, and the result is still correct.

Top module: `vec_lane_exec`

## Requirements
- R1: In mode 00, every destination element below the active length receives the sum of element 0 of source A and element 0 of source B, computed from the source values present at launch.
- R2: In mode 01, every destination element i below the active length receives A[i] + B[i].
- R3: In mode 10, element i below the active length receives A[i] + B[i] if bit i of the mask is 1, and zero if the bit is 0.
- R4: In mode 11, element i below the active length receives A[i] + B[i] if bit i of the mask is 0, and zero if the bit is 1.
- R5: Every element i with active length <= i < maximum length is written with zero, and no write enable is raised for an index at or above the maximum length.
- R6: With an active length of zero, all elements below the maximum length are written with zero, whatever the mode.
- R7: After the start edge, `elem_base_o` takes the values 0, LANES, 2*LANES and so on in consecutive cycles while `busy_o` is high. `busy_o` stays high for ceil(maximum length / LANES) cycles. `done_o` is high for exactly one cycle, the cycle after the last group's write edge.
- R8: When the destination is the same register as a source, the result equals the result computed from the source values present at launch.
- R9: A start pulse that arrives while `busy_o` is high has no effect on the running operation, on its length, mode, mask or timing.
- R10: An active length above the maximum length is treated as equal to the maximum length, and a maximum length above `MAX_LEN` is treated as `MAX_LEN`.
- R11: Out of reset, `busy_o`, `done_o` and every write enable are low, and no write enable is raised while `busy_o` is low.
- R12: The add wraps modulo 2^ELEM_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse; ignored while busy |
| len_i | input | LEN_W | Active length, sampled at launch |
| maxlen_i | input | LEN_W | Register maximum length, sampled at launch |
| mode_i | input | 2 | Shape/mask mode, sampled at launch |
| mask_i | input | MAX_LEN | Mask register element LSBs, bit i for element i, sampled at launch |
| elem_base_o | output | IDX_W | Index of the current group's lane 0 element (read and write) |
| src_a_i | input | LANES*ELEM_W | Source A elements base..base+LANES-1, lane l at bits l*ELEM_W |
| src_b_i | input | LANES*ELEM_W | Source B elements, same layout |
| wr_en_o | output | LANES | Per-lane destination write enable |
| wr_data_o | output | LANES*ELEM_W | Destination write data, same layout |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with LANES = 2, ELEM_W = 32 and MAX_LEN = 16. Two lanes mean that odd active and maximum lengths, such as 5, 7 and 9, end partway through a lane group. This exercises the partial final group, the boundary where the tail zeroing begins, and the cycle count for a group count that rounds up. A 16-entry mask and maximum length allow an alternating mask pattern, an active length clamped down to a smaller maximum, and in-place operation. The in-place runs cover both scalar mode and vector mode, with a destination that overwrites element 0 after the first group has been read.

// File: rtl/vle_pkg.sv
package vle_pkg;
  typedef enum logic [1:0] {
    MODE_SCALAR   = 2'b00,
    MODE_PLAIN    = 2'b01,
    MODE_WHEN_SET = 2'b10,
    MODE_WHEN_CLR = 2'b11
  } vmode_e;
endpackage

// File: rtl/vle_seq.sv
module vle_seq #(
  parameter int LANES   = 2,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int IDX_W   = $clog2(MAX_LEN + LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] maxlen_i,
  output logic             launch_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             first_o,
  output logic [IDX_W-1:0] base_o,
  output logic [LEN_W-1:0] maxlen_o
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] base_q, base_d;
  logic [LEN_W-1:0] maxl_q, maxl_d;
  logic             base_en;
  logic             last;
  logic [IDX_W:0]   next_end;

  assign launch_o = start_i && !busy_q;
  assign next_end = {1'b0, base_q} + (IDX_W+1)'(LANES);
  assign last     = next_end >= (IDX_W+1)'(maxl_q);
  assign base_en  = launch_o || busy_q;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    base_d = base_q;
    maxl_d = maxl_q;
    if (launch_o) begin
      busy_d = 1'b1;
      base_d = '0;
      maxl_d = (maxlen_i > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : maxlen_i;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        base_d = next_end[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maxl_q <= '0;
    end else if (launch_o) begin
      maxl_q <= maxl_d;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign first_o  = busy_q && (base_q == '0);
  assign base_o   = base_q;
  assign maxlen_o = maxl_q;

  // R7: completion pulse lasts one cycle only
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: done follows a busy period and is never raised together with busy
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !busy_q && $past(busy_q));

  // R9: a start during a run neither restarts nor stalls the walk
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !last) |=> busy_q && (base_q == $past(base_q) + IDX_W'(LANES)));
endmodule

// File: rtl/vle_lane.sv
module vle_lane
  import vle_pkg::*;
#(
  parameter int ELEM_W = 32,
  parameter int LEN_W  = 5,
  parameter int IDX_W  = 5
) (
  input  logic              active_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LEN_W-1:0]  maxlen_i,
  input  vmode_e            mode_i,
  input  logic              mask_bit_i,
  input  logic [ELEM_W-1:0] a_i,
  input  logic [ELEM_W-1:0] b_i,
  input  logic [ELEM_W-1:0] scalar_i,
  output logic              we_o,
  output logic [ELEM_W-1:0] data_o
);
  logic [ELEM_W-1:0] sum;
  logic              in_body;

  assign sum     = a_i + b_i;
  assign in_body = idx_i < IDX_W'(len_i);
  assign we_o    = active_i && (idx_i < IDX_W'(maxlen_i));

  always_comb begin
    data_o = '0;
    if (in_body) begin
      unique case (mode_i)
        MODE_SCALAR:   data_o = scalar_i;
        MODE_PLAIN:    data_o = sum;
        MODE_WHEN_SET: data_o = mask_bit_i ? sum : '0;
        MODE_WHEN_CLR: data_o = mask_bit_i ? '0 : sum;
        default:       data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_lane_exec.sv
module vec_lane_exec
  import vle_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int ELEM_W  = 32,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int IDX_W   = $clog2(MAX_LEN + LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic [LEN_W-1:0]        maxlen_i,
  input  logic [1:0]              mode_i,
  input  logic [MAX_LEN-1:0]      mask_i,
  output logic [IDX_W-1:0]        elem_base_o,
  input  logic [LANES*ELEM_W-1:0] src_a_i,
  input  logic [LANES*ELEM_W-1:0] src_b_i,
  output logic [LANES-1:0]        wr_en_o,
  output logic [LANES*ELEM_W-1:0] wr_data_o,
  output logic                    busy_o,
  output logic                    done_o
);
  localparam int MI_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic             launch, busy, done, first;
  logic [IDX_W-1:0] base;
  logic [LEN_W-1:0] maxl_q;
  logic [LEN_W-1:0] len_q, len_d;
  vmode_e           mode_q;
  logic [MAX_LEN-1:0] mask_q;
  logic [ELEM_W-1:0]  hold_q, scalar_val, lane0_sum;
  logic             hold_en;
  logic [IDX_W-1:0] lane_idx [LANES];
  logic             lane_mbit [LANES];

  vle_seq #(
    .LANES(LANES), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .maxlen_i(maxlen_i),
    .launch_o(launch), .busy_o(busy), .done_o(done), .first_o(first),
    .base_o(base), .maxlen_o(maxl_q)
  );

  always_comb begin
    len_d = len_i;
    if (len_d > maxlen_i) len_d = maxlen_i;
    if (len_d > LEN_W'(MAX_LEN)) len_d = LEN_W'(MAX_LEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      mode_q <= MODE_PLAIN;
      mask_q <= '0;
    end else if (launch) begin
      len_q  <= len_d;
      mode_q <= vmode_e'(mode_i);
      mask_q <= mask_i;
    end
  end

  // scalar result is taken from element 0 in the first group and held,
  // so an in-place destination cannot corrupt it
  assign lane0_sum  = src_a_i[ELEM_W-1:0] + src_b_i[ELEM_W-1:0];
  assign hold_en    = first;
  assign scalar_val = first ? lane0_sum : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= lane0_sum;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_idx[l]  = base + IDX_W'(l);
    assign lane_mbit[l] = (lane_idx[l] < IDX_W'(MAX_LEN)) ? mask_q[lane_idx[l][MI_W-1:0]] : 1'b0;

    vle_lane #(.ELEM_W(ELEM_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_lane (
      .active_i  (busy),
      .idx_i     (lane_idx[l]),
      .len_i     (len_q),
      .maxlen_i  (maxl_q),
      .mode_i    (mode_q),
      .mask_bit_i(lane_mbit[l]),
      .a_i       (src_a_i[l*ELEM_W +: ELEM_W]),
      .b_i       (src_b_i[l*ELEM_W +: ELEM_W]),
      .scalar_i  (scalar_val),
      .we_o      (wr_en_o[l]),
      .data_o    (wr_data_o[l*ELEM_W +: ELEM_W])
    );

    // R5: tail elements carry zero
    p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o[l] && lane_idx[l] >= IDX_W'(len_q)) |-> (wr_data_o[l*ELEM_W +: ELEM_W] == '0));

    // R5: no write beyond the register maximum length
    p_wr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o[l] |-> (lane_idx[l] < IDX_W'(maxl_q)));

    // R3: masked-off element in set-mode carries zero
    p_maskoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o[l] && mode_q == MODE_WHEN_SET && !lane_mbit[l])
        |-> (wr_data_o[l*ELEM_W +: ELEM_W] == '0));
  end

  // R11: writes only happen during a run
  p_write_needs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en_o) |-> busy);

  assign elem_base_o = base;
  assign busy_o      = busy;
  assign done_o      = done;
endmodule

// File: tb/vec_lane_exec_test.sv
module vec_lane_exec_test;
  localparam int LANES = 2;
  localparam int EW    = 32;
  localparam int ML    = 16;
  localparam int LW    = $clog2(ML + 1);
  localparam int IW    = $clog2(ML + LANES);

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [LW-1:0] len, maxlen;
  logic [1:0] mode;
  logic [ML-1:0] mask;
  logic [IW-1:0] base;
  logic [LANES*EW-1:0] src_a, src_b, wdata;
  logic [LANES-1:0] wen;
  logic busy, done;

  logic [EW-1:0] rf [4][ML];
  int sa, sb, sd;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  vec_lane_exec #(.LANES(LANES), .ELEM_W(EW), .MAX_LEN(ML)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .len_i(len), .maxlen_i(maxlen),
    .mode_i(mode), .mask_i(mask), .elem_base_o(base), .src_a_i(src_a),
    .src_b_i(src_b), .wr_en_o(wen), .wr_data_o(wdata), .busy_o(busy), .done_o(done)
  );

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      int ix;
      ix = int'(base) + l;
      src_a[l*EW +: EW] = (ix < ML) ? rf[sa][ix] : '0;
      src_b[l*EW +: EW] = (ix < ML) ? rf[sb][ix] : '0;
    end
  end

  always @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      int ix;
      ix = int'(base) + l;
      if (wen[l] && ix < ML) rf[sd][ix] <= wdata[l*EW +: EW];
    end
  end

  task automatic chk(input string tag, input logic [EW-1:0] act, input logic [EW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fill(input int r, input int seed);
    for (int i = 0; i < ML; i++) rf[r][i] = 32'h1000_0000 * (r + 1) + seed * 97 + i * 13;
  endtask

  // runs one operation and checks timing plus the whole destination
  task automatic run_op(input string tag, input int a, input int b, input int d,
                        input int ln, input int mx, input logic [1:0] md,
                        input logic [ML-1:0] mk, input bit restart);
    logic [EW-1:0] ea [ML], eb [ML], ed [ML], exp_v, s;
    int eff, cmax, cnt, wd, groups;
    sa = a; sb = b; sd = d;
    for (int i = 0; i < ML; i++) begin ea[i] = rf[a][i]; eb[i] = rf[b][i]; ed[i] = rf[d][i]; end
    cmax = (mx > ML) ? ML : mx;
    eff  = (ln > cmax) ? cmax : ln;
    groups = (cmax + LANES - 1) / LANES;
    s = ea[0] + eb[0];
    @(negedge clk);
    len = LW'(ln); maxlen = LW'(mx); mode = md; mask = mk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0; wd = 0;
    while (!done && wd < 100) begin
      if (busy) begin
        chk("R7 base", 32'(base), 32'(cnt * LANES));
        cnt++;
        if (restart && cnt == 1) begin
          start = 1'b1; len = LW'(1); mode = ~md; mask = ~mk; maxlen = LW'(2);
        end else begin
          start = 1'b0;
        end
      end
      @(negedge clk);
      wd++;
    end
    start = 1'b0;
    if (wd >= 100) chk("R7 watchdog", 32'd1, 32'd0);
    chk({tag, " R7 cycles"}, 32'(cnt), 32'(groups));
    chk("R7 done", 32'(done), 32'd1);
    chk("R7 busy at done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R7 done pulse", 32'(done), 32'd0);
    for (int i = 0; i < ML; i++) begin
      if (i >= cmax) exp_v = ed[i];
      else if (i >= eff) exp_v = '0;
      else case (md)
        2'b00: exp_v = s;
        2'b01: exp_v = ea[i] + eb[i];
        2'b10: exp_v = mk[i] ? ea[i] + eb[i] : '0;
        default: exp_v = mk[i] ? '0 : ea[i] + eb[i];
      endcase
      chk($sformatf("%s elem %0d%s", tag, i, (i >= eff) ? " R5 tail" : ""), rf[d][i], exp_v);
    end
  endtask

  task automatic t_reset;
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 done", 32'(done), 32'd0);
    chk("R11 wen", 32'(wen), 32'd0);
  endtask

  task automatic t_plain;     fill(0, 1); fill(1, 2); fill(2, 3); run_op("R2", 0, 1, 2, 5, 8, 2'b01, '0, 0); endtask
  task automatic t_scalar;    fill(0, 4); fill(1, 5); run_op("R1 R8", 0, 1, 0, 5, 8, 2'b00, '0, 0); endtask
  task automatic t_mset;      fill(0, 6); fill(1, 7); fill(3, 8); run_op("R3", 0, 1, 3, 7, 16, 2'b10, 16'hA5C3, 0); endtask
  task automatic t_mclr;      fill(0, 9); fill(1, 10); fill(3, 11); run_op("R4", 0, 1, 3, 7, 16, 2'b11, 16'hA5C3, 0); endtask
  task automatic t_zero_len;  fill(2, 12); run_op("R6", 0, 1, 2, 0, 16, 2'b01, '1, 0); endtask
  task automatic t_clamp;     fill(2, 13); run_op("R10", 0, 1, 2, 20, 9, 2'b01, '0, 0); endtask
  task automatic t_inplace;   fill(1, 14); fill(2, 15); run_op("R8", 1, 2, 1, 11, 16, 2'b01, '0, 0); endtask
  task automatic t_restart;   fill(0, 16); fill(1, 17); fill(3, 18); run_op("R9", 0, 1, 3, 9, 16, 2'b10, 16'h3C96, 1); endtask

  task automatic t_wrap;
    for (int i = 0; i < ML; i++) begin rf[0][i] = 32'hFFFF_FFFF - i; rf[1][i] = 32'h0000_0002 + 2 * i; end
    fill(2, 19);
    run_op("R12", 0, 1, 2, 16, 16, 2'b01, '0, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; len = '0; maxlen = '0; mode = '0; mask = '0;
    sa = 0; sb = 1; sd = 2;
    for (int r = 0; r < 4; r++) fill(r, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_scalar();
    t_mset();
    t_mclr();
    t_zero_len();
    t_clamp();
    t_inplace();
    t_restart();
    t_wrap();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog R7: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule